// File: doc/BRIEF.md
# RTC Periodic Tick Timer

This block produces a periodic interrupt for a real-time clock. A free-running prescaler counts cycles of a 32768 Hz enable strobe. A clock-select field in the control register picks how many of its low bits must roll over before one decrement opportunity occurs, so the tick rate is 32768 / 2^S Hz. A down-counter loaded from a software reload value counts these opportunities. When the counter expires, the block sets a sticky status bit, raises the tick interrupt and reloads for the next period.

Software works through a small word-wide register port with one write strobe and a combinational read address. The port gives access to a control word, a reload word, the live counter and the status bit. The timer starts only on a deliberate rising edge of the tick enable bit, and only while the master enable is set and a nonzero reload is held. Either enable can stop it. The status bit is cleared by writing a one to it.

Top module: `rtc_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the control, reload, count and status values read back as zero, `tick_irq` is low and the timer is stopped.
- R2: A write to address 1 (reload) is stored only when the full 32-bit write value is greater than 2; otherwise the stored reload keeps its old value.
- R3: A write to address 0 (control) whose bit 0 (master enable) and bit 8 (tick enable) are both 1, while the stored bit 8 is 0 and the stored reload is nonzero, starts the timer and loads the count with the stored reload value.
- R4: A control write does not start or restart the timer when bit 8 is already set in the stored control word, when the written bit 0 is 0, or when the stored reload is zero. A running timer keeps counting with the new clock-select field.
- R5: A 15-bit prescaler counts strobe cycles from reset. A decrement opportunity occurs on a strobe cycle in which the low S bits of the prescaler, taken before the increment, are all ones, where S is control bits [7:4]. With S = 0, every strobe is an opportunity.
- R6: On an opportunity while running, a count of 1 is replaced by the current reload value and sets status bit 0, and `tick_irq` is high from the next cycle. Any other count decrements by one. A running count is never zero.
- R7: A control write with bit 0 = 1 that clears a stored bit 8 of 1 stops the timer. The count holds its value and is not decremented in that cycle. While stopped, the count does not change.
- R8: A control write that clears a stored bit 0 of 1 stops the timer in the same way.
- R9: Writing address 3 (status) with bit 0 = 1 clears the status bit and lowers `tick_irq`, and writing 0 there has no effect. If an expiry occurs in the same cycle, the status bit stays set.
- R10: The read map is: address 0 gives the whole stored control word (every write is stored), 1 the reload, 2 the live count, and 3 the status in bit 0 with zero above. A write to address 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_32k | input | 1 | One-cycle enable at the 32768 Hz timebase rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| tick_irq | output | 1 | Tick interrupt, mirrors status bit 0 |

## Verification
Directed sequences first apply the start conditions one at a time: a zero reload, a clear master enable, and a tick enable that is already set. Only the true rising edge may load the counter. Each tick-enable stop, master-enable stop and clock-select change is then applied to a running timer, which separates a frozen count from one that is still decrementing. Strobes arriving every cycle with a select of 0 and then of 2 show whether the prescaler bit mask is right. A status clear placed exactly on the expiry cycle shows whether set or clear wins. A long random run mixes sparse strobes, rejected and accepted reload values, writes to every address and random control words. It compares the interrupt and a rotating read address with a reference model on every cycle.

// File: rtl/rtc_tick_pkg.sv
// Package: shared register addresses and control field positions for the
// RTC tick timer. Assumes a two-bit word address space.
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT   = 0;   // master enable
    localparam int CTRL_SEL_LSB  = 4;   // clock-select field low bit
    localparam int CTRL_TICK_BIT = 8;   // tick timer enable
    localparam int STAT_TICK_BIT = 0;   // tick pending flag
    localparam int RELOAD_FLOOR  = 2;   // reload values at or below this are refused

endpackage

// File: rtl/rtc_tick_prescaler.sv
// Module: free-running prescaler. Counts strobe cycles in a PRE_W-bit
// counter and flags a decrement opportunity when the low sel_i bits are all
// ones on a strobe cycle. Assumes 2**SEL_W - 1 <= PRE_W.
module rtc_tick_prescaler #(
    parameter int PRE_W = 15,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask;

    // one mask bit per prescaler stage: set when the stage lies below sel_i
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign sel_mask[i] = (int'(sel_i) > i);
    end

    // purpose: opportunity when every selected low bit is about to roll over
    assign tick_o = strobe_i && ((pre_q & sel_mask) == sel_mask);

    // purpose: advance the prescaler once per strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (strobe_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/rtc_tick_counter.sv
// Module: reloadable down-counter with a run flag. Loads on start, freezes
// on stop, and on each tick either decrements or, at one, reloads and
// reports an expiry. Assumes start and stop never coincide.
module rtc_tick_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             at_last;

    assign at_last  = (cnt_q == CNT_W'(1));

    // purpose: an expiry happens only on a decrement that is actually taken
    assign expire_o = run_q && tick_i && at_last && !stop_i;

    // purpose: run flag and count update, control writes first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            cnt_q <= reload_i;
        end else if (stop_i) begin
            run_q <= 1'b0;
        end else if (run_q && tick_i) begin
            cnt_q <= at_last ? reload_i : (cnt_q - CNT_W'(1));
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = run_q;

endmodule

// File: rtl/rtc_tick_regs.sv
// Module: register file of the tick timer. Holds the control word, reload
// and status flag, decodes start/stop from control writes, and drives the
// combinational read mux. Assumes CNT_W <= DATA_W and DATA_W > 8.
module rtc_tick_regs
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              expire_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              stat_o,
    output logic              start_o,
    output logic              stop_o
);

    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic              stat_q;
    logic              wr_ctrl, wr_reload, wr_status;
    logic              reload_ok;
    logic              clear_req;

    assign wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
    assign wr_reload = wr_en && (wr_addr == REG_RELOAD);
    assign wr_status = wr_en && (wr_addr == REG_STATUS);
    assign reload_ok = (wr_data > DATA_W'(RELOAD_FLOOR));
    assign clear_req = wr_status && wr_data[STAT_TICK_BIT];

    // purpose: start only on a rising tick enable with master on and reload held
    assign start_o = wr_ctrl && wr_data[CTRL_EN_BIT] && wr_data[CTRL_TICK_BIT]
                     && !ctrl_q[CTRL_TICK_BIT] && (reload_q != '0);

    // purpose: stop on master falling, or tick enable falling under master
    assign stop_o  = wr_ctrl &&
                     ((ctrl_q[CTRL_EN_BIT] && !wr_data[CTRL_EN_BIT]) ||
                      (wr_data[CTRL_EN_BIT] && ctrl_q[CTRL_TICK_BIT] &&
                       !wr_data[CTRL_TICK_BIT]));

    // purpose: control word stored on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_data;
        end
    end

    // purpose: reload stored only when above the floor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else if (wr_reload && reload_ok) begin
            reload_q <= wr_data[CNT_W-1:0];
        end
    end

    // purpose: sticky tick flag, expiry wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (expire_i) begin
            stat_q <= 1'b1;
        end else if (clear_req) begin
            stat_q <= 1'b0;
        end
    end

    // purpose: combinational read mux, narrow fields zero-extended
    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = ctrl_q;
            REG_RELOAD: rd_data = DATA_W'(reload_q);
            REG_COUNT:  rd_data = DATA_W'(cnt_i);
            default:    rd_data = DATA_W'(stat_q);
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
    assign stat_o   = stat_q;

endmodule

// File: rtl/rtc_tick_timer.sv
// Module: top of the RTC periodic tick timer. Ties the register file, the
// strobe prescaler and the reloadable down-counter together. Assumes the
// 32768 Hz strobe is already synchronous to clk and one cycle wide.
module rtc_tick_timer
    import rtc_tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 15,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_32k,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick_irq
);

    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SEL_W-1:0]  clk_sel;
    logic              stat_q;
    logic              start_pulse, stop_pulse;
    logic              tick, expire, run_q;

    assign clk_sel = ctrl_q[CTRL_SEL_LSB +: SEL_W];

    rtc_tick_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .expire_i (expire),
        .cnt_i    (cnt_q),
        .rd_data  (rd_data),
        .ctrl_o   (ctrl_q),
        .reload_o (reload_q),
        .stat_o   (stat_q),
        .start_o  (start_pulse),
        .stop_o   (stop_pulse)
    );

    rtc_tick_prescaler #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_32k),
        .sel_i    (clk_sel),
        .tick_o   (tick)
    );

    rtc_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_pulse),
        .stop_i   (stop_pulse),
        .tick_i   (tick),
        .reload_i (reload_q),
        .cnt_o    (cnt_q),
        .run_o    (run_q),
        .expire_o (expire)
    );

    assign tick_irq = stat_q;

endmodule

// File: rtl/rtc_tick_checker.sv
// Module: protocol checker for rtc_tick_timer, bound into the top.
// Relates the register file, counter and outputs over time.
module rtc_tick_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run_q,
    input logic              start_pulse,
    input logic              expire,
    input logic              tick_irq
);

    assert_reject_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && wr_data <= DATA_W'(2)) |=> $stable(reload_q));

    assert_start_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (run_q && cnt_q == $past(reload_q)));

    assert_expire_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> tick_irq);

    assert_running_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q != '0));

    assert_idle_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !start_pulse) |=> $stable(cnt_q));

    assert_run_needs_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (ctrl_q[0] && ctrl_q[8]));

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && wr_data[0] && !expire) |=> !tick_irq);

endmodule

bind rtc_tick_timer rtc_tick_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ctrl_q      (ctrl_q),
    .reload_q    (reload_q),
    .cnt_q       (cnt_q),
    .run_q       (run_q),
    .start_pulse (start_pulse),
    .expire      (expire),
    .tick_irq    (tick_irq)
);

// File: tb/tb_rtc_tick_timer.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic, every cycle
// compared against a reference model built from the requirements.
module tb_rtc_tick_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_32k;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [1:0]  rd_addr;
    logic [31:0] rd_data;
    logic        tick_irq;

    always #4 clk = ~clk;   // 125 MHz

    rtc_tick_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_32k (strobe_32k),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .tick_irq   (tick_irq)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string phase   = "R1";

    // reference model state
    logic [14:0] m_pre;
    logic [31:0] m_ctrl, m_rel, m_cnt;
    logic        m_run, m_stat;

    function automatic logic [31:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_ctrl;
            2'd1:    return m_rel;
            2'd2:    return m_cnt;
            default: return {31'd0, m_stat};
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one model cycle from the requirements, using pre-edge state
    task automatic model_cycle(bit w, logic [1:0] a, logic [31:0] d, bit s);
        logic [31:0] mask;
        logic [31:0] n_cnt;
        bit tick, expire, n_run, stopping;
        mask     = (32'd1 << m_ctrl[7:4]) - 32'd1;                 // R5
        tick     = s && ((m_pre & mask[14:0]) == mask[14:0]);
        n_cnt    = m_cnt;
        n_run    = m_run;
        expire   = 1'b0;
        stopping = 1'b0;
        if (m_run && tick) begin                                     // R6
            if (m_cnt == 32'd1) begin
                n_cnt  = m_rel;
                expire = 1'b1;
            end else begin
                n_cnt = m_cnt - 32'd1;
            end
        end
        if (w && a == 2'd0) begin
            if (d[0] && d[8] && !m_ctrl[8] && m_rel != 32'd0) begin  // R3
                n_run = 1'b1;
                n_cnt = m_rel;
            end else if ((m_ctrl[0] && !d[0]) ||                      // R8
                         (d[0] && m_ctrl[8] && !d[8])) begin          // R7
                stopping = 1'b1;
            end
        end
        if (stopping) begin
            n_run  = 1'b0;
            n_cnt  = m_cnt;
            expire = 1'b0;
        end
        if (w && a == 2'd0) m_ctrl = d;                               // R10
        if (w && a == 2'd1 && d > 32'd2) m_rel = d;                   // R2
        if (w && a == 2'd3 && d[0]) m_stat = 1'b0;                    // R9
        if (expire) m_stat = 1'b1;
        if (s) m_pre = m_pre + 15'd1;
        m_cnt = n_cnt;
        m_run = n_run;
    endtask

    // compare the previous cycle's result, then drive and model the next
    task automatic step(bit w, logic [1:0] a, logic [31:0] d, bit s, logic [1:0] ra);
        @(negedge clk);
        check(tick_irq === m_stat, {phase, " irq"}, {31'd0, tick_irq}, {31'd0, m_stat});
        check(rd_data === exp_read(rd_addr), {phase, " read"}, rd_data, exp_read(rd_addr));
        wr_en      = w;
        wr_addr    = a;
        wr_data    = d;
        strobe_32k = s;
        rd_addr    = ra;
        model_cycle(w, a, d, s);
    endtask

    task automatic idle(int n, bit s, logic [1:0] ra);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, s, ra);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        rst_n = 1'b0; strobe_32k = 1'b0; wr_en = 1'b0;
        wr_addr = 2'd0; wr_data = 32'd0; rd_addr = 2'd0;
        m_pre = '0; m_ctrl = '0; m_rel = '0; m_cnt = '0; m_run = 1'b0; m_stat = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        phase = "R1";
        for (int a = 0; a < 4; a++) idle(1, 1'b0, 2'(a));

        // R4: start attempt with zero reload must not run
        phase = "R4";
        step(1'b1, 2'd0, 32'h101, 1'b0, 2'd2);
        idle(6, 1'b1, 2'd2);
        step(1'b1, 2'd0, 32'h000, 1'b0, 2'd0);

        // R2: reloads at or below two are refused
        phase = "R2";
        step(1'b1, 2'd1, 32'd2, 1'b0, 2'd1);
        step(1'b1, 2'd1, 32'd1, 1'b0, 2'd1);
        step(1'b1, 2'd1, 32'd3, 1'b0, 2'd1);
        step(1'b1, 2'd1, 32'd0, 1'b0, 2'd1);
        step(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 2'd1);
        step(1'b1, 2'd1, 32'd5, 1'b0, 2'd1);

        // R4: tick enable without master, then master with tick already set
        phase = "R4";
        step(1'b1, 2'd0, 32'h100, 1'b0, 2'd2);
        step(1'b1, 2'd0, 32'h101, 1'b0, 2'd2);
        idle(6, 1'b1, 2'd2);

        // R10: count address write ignored
        phase = "R10";
        step(1'b1, 2'd2, 32'd9, 1'b0, 2'd2);
        idle(1, 1'b0, 2'd2);

        // R3: proper rising edge of tick enable under master enable
        phase = "R3";
        step(1'b1, 2'd0, 32'h001, 1'b0, 2'd2);
        step(1'b1, 2'd0, 32'h101, 1'b0, 2'd2);
        idle(1, 1'b0, 2'd2);

        // R5/R6: select 0, strobe every cycle, through expiry
        phase = "R6";
        idle(12, 1'b1, 2'd2);

        // R9: write 0 keeps the flag, write 1 clears it
        phase = "R9";
        step(1'b1, 2'd3, 32'hFFFF_FFFE, 1'b0, 2'd3);
        step(1'b1, 2'd3, 32'h1, 1'b0, 2'd3);
        idle(1, 1'b0, 2'd3);

        // R5: select 2 applied while running, no restart
        phase = "R5";
        step(1'b1, 2'd0, 32'h121, 1'b0, 2'd2);
        idle(40, 1'b1, 2'd2);

        // R7: tick enable cleared under master stops and freezes the count
        phase = "R7";
        step(1'b1, 2'd0, 32'h021, 1'b1, 2'd2);
        idle(12, 1'b1, 2'd2);

        // R8: master enable cleared stops the timer
        phase = "R8";
        step(1'b1, 2'd0, 32'h121, 1'b0, 2'd2);
        idle(9, 1'b1, 2'd2);
        step(1'b1, 2'd0, 32'h120, 1'b1, 2'd2);
        idle(12, 1'b1, 2'd2);

        // R9: clear landing on the expiry cycle leaves the flag set
        phase = "R9";
        step(1'b1, 2'd1, 32'd3, 1'b0, 2'd3);
        step(1'b1, 2'd0, 32'h001, 1'b0, 2'd3);
        step(1'b1, 2'd0, 32'h101, 1'b0, 2'd3);
        step(1'b1, 2'd3, 32'h1, 1'b1, 2'd3);
        step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3);
        step(1'b1, 2'd3, 32'h1, 1'b1, 2'd3);
        idle(2, 1'b0, 2'd3);

        // R10: seeded random traffic against the model
        phase = "R10 random";
        for (int i = 0; i < 3000; i++) begin
            bit          w;
            logic [1:0]  a;
            logic [31:0] d;
            w = ($urandom_range(0, 9) == 0);
            a = 2'($urandom_range(0, 3));
            d = $urandom;
            if (a == 2'd1) d = $urandom_range(0, 7);
            if (a == 2'd0) begin
                d = ($urandom & 32'hFFFF_FE0E)
                    | (32'($urandom_range(0, 2)) << 4)
                    | (32'($urandom_range(0, 1)) << 8)
                    | 32'($urandom_range(0, 4) != 0);
            end
            step(w, a, d, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
        end
        idle(1, 1'b0, 2'd2);

        done = 1'b1;
        finish_run();
    end

endmodule